// File: doc/BRIEF.md
# Note Message Assembler with Running-Status Restoration

This block sits after a serial byte receiver in a music-controller datapath. It takes received bytes one at a time and rebuilds full three-byte note messages: a status byte, a key byte and a velocity byte. Senders often skip a status byte that repeats the previous one. The block keeps the last note status it saw and puts it back in front of every key/velocity pair. Each output word is therefore a self-contained 24-bit message that later stages (queues, merge logic) can handle without any context.

Bytes come in on a valid/ready port and messages leave on another valid/ready port, both on one clock. A byte is taken on a rising edge when `in_valid` and `in_ready` are both high. A message is handed over on a rising edge when `out_valid` and `out_ready` are both high. There is one output holding register. While it holds a message that has not been taken, `in_ready` is low and the input waits. When the downstream side keeps `out_ready` high, the input is never stalled.

Top module: `midi_msg_assembler`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), `out_valid` is 0, `out_msg` is 0 and `in_ready` is 1.
- R2: A note status byte (top three bits 100, i.e. 0x80 to 0x9F), followed by two data bytes (top bit 0), produces one message. The message has the status in bits 23:16, the first data byte (key) in bits 15:8 and the second (velocity) in bits 7:0. `out_valid` rises in the cycle after the edge that accepts the velocity byte.
- R3: After a message completes, the stored status is kept. Each further pair of data bytes produces a new message carrying that same status.
- R4: A velocity of 0x00 is not treated specially. The message is emitted with velocity 0x00 and the status unchanged.
- R5: Data bytes accepted after reset, before any note status byte, produce no message.
- R6: A note status byte that arrives after only a key byte drops that key. The next two data bytes form a message with the new status.
- R7: Any other status byte in 0xA0 to 0xF7 cancels the stored status and any pending key. Data bytes after it produce no message until a new note status byte arrives.
- R8: Bytes 0xF8 to 0xFF are accepted and have no effect. They may appear between key and velocity without changing the message.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_msg` stays unchanged and `in_ready` is low. No byte is taken until the message is accepted.
- R10: With `out_ready` high, `out_valid` is high for exactly one cycle per message. `out_msg` keeps its value until the next message is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | An assembled message is offered |
| out_ready | input | 1 | Downstream takes the message this cycle |
| out_msg | output | 24 | Message: status 23:16, key 15:8, velocity 7:0 |

## Verification
The bench targets the points where running status goes wrong:
- Data bytes arriving before any status byte: a design that invents a status here emits spurious messages.
- A status byte arriving halfway through a pair: a design that keeps the half-pair count pairs the stale key with the wrong velocity.
- Non-note status bytes: a design that fails to cancel the stored status emits controller data as note messages.
- Real-time bytes placed between key and velocity: a design that treats them as data or status shifts or drops the message.
- A stall on the output port: a design that lets the word change, or keeps taking bytes during the stall, loses or corrupts a message.

// File: rtl/midi_asm_pkg.sv
package midi_asm_pkg;
  localparam int BYTE_W = 8;
  localparam int MSG_W  = 3 * BYTE_W;

  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_NOTE  = 2'd1,
    K_OTHER = 2'd2,
    K_RTIME = 2'd3
  } byte_kind_t;
endpackage

// File: rtl/midi_byte_classifier.sv
module midi_byte_classifier
  import midi_asm_pkg::*;
(
  input  logic [4:0]  hi_bits,
  output byte_kind_t  kind
);
  // hi_bits are the five most significant bits of the byte
  always_comb begin
    if (!hi_bits[4])                 kind = K_DATA;
    else if (&hi_bits)               kind = K_RTIME;
    else if (hi_bits[3:2] == 2'b00)  kind = K_NOTE;
    else                             kind = K_OTHER;
  end
endmodule

// File: rtl/midi_status_tracker.sv
module midi_status_tracker
  import midi_asm_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int MW = 3 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [BW-1:0] data,
  input  byte_kind_t    kind,
  output logic          complete,
  output logic [MW-1:0] msg
);
  logic [BW-1:0] status_q;
  logic [BW-1:0] key_q;
  logic          have_q;
  logic          half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      key_q    <= '0;
      have_q   <= 1'b0;
      half_q   <= 1'b0;
    end else if (take) begin
      unique case (kind)
        K_NOTE: begin
          status_q <= data;
          have_q   <= 1'b1;
          half_q   <= 1'b0;
        end
        K_OTHER: begin
          have_q <= 1'b0;
          half_q <= 1'b0;
        end
        K_RTIME: ;
        K_DATA: begin
          if (have_q) begin
            if (!half_q) key_q <= data;
            half_q <= !half_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign complete = take && (kind == K_DATA) && have_q && half_q;
  assign msg      = {status_q, key_q, data};
endmodule

// File: rtl/midi_msg_out_stage.sv
module midi_msg_out_stage #(
  parameter int MW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] load_msg,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [MW-1:0] out_msg,
  output logic          can_take
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_msg   <= load_msg;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign can_take = !out_valid || out_ready;
endmodule

// File: rtl/midi_msg_assembler.sv
module midi_msg_assembler
  import midi_asm_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int MW = 3 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [MW-1:0] out_msg
);
  byte_kind_t    kind;
  logic          take;
  logic          complete;
  logic [MW-1:0] msg;

  assign take = in_valid && in_ready;

  midi_byte_classifier u_cls (
    .hi_bits (in_byte[BW-1 -: 5]),
    .kind    (kind)
  );

  midi_status_tracker #(.BW(BW)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .data     (in_byte),
    .kind     (kind),
    .complete (complete),
    .msg      (msg)
  );

  midi_msg_out_stage #(.MW(MW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (complete),
    .load_msg  (msg),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_msg   (out_msg),
    .can_take  (in_ready)
  );
endmodule

// File: rtl/midi_asm_checker.sv
module midi_asm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_msb,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_msg
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_msg[23:21] == 3'b100));

  p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_msg[15] && !out_msg[7]));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready && !in_msb)) |=> !out_valid);
endmodule

bind midi_msg_assembler midi_asm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_msb    (in_byte[7]),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_msg   (out_msg)
);

// File: tb/midi_msg_assembler_tb_top.sv
`timescale 1ns/1ps
module midi_msg_assembler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_msg;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] expq[$];

  always #10 clk = ~clk;

  midi_msg_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_msg(out_msg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every handshake is compared with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected message", {8'h0, out_msg}, 32'h0);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk(out_msg == e, "R2/R3 message content", {8'h0, out_msg}, {8'h0, e});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic send_msg(input logic [7:0] k, input logic [7:0] v, input logic [23:0] e, input string req);
    expq.push_back(e);
    send(k);
    send(v);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_msg == e, req, {7'h0, out_valid, out_msg}, {8'h01, e});
    @(negedge clk);
    chk(out_valid == 1'b0 && out_msg == e, "R10 single pulse and hold", {7'h0, out_valid, out_msg}, {8'h00, e});
  endtask

  task automatic idle_check(input string req);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && expq.size() == 0, req, {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk(out_valid == 1'b0 && out_msg == 24'h0 && in_ready == 1'b1, "R1 reset state",
        {6'h0, in_ready, out_valid, out_msg}, {6'h0, 1'b1, 1'b0, 24'h0});
    @(posedge clk); #2; rst_n = 1'b1;

    // R5: data before any status byte is dropped
    send(8'h40); send(8'h50);
    idle_check("R5 no message before status");

    // R2: plain note-on
    send(8'h93);
    send_msg(8'h3C, 8'h64, 24'h933C64, "R2 note-on message");
    // R3 and R4: running status, zero velocity
    send_msg(8'h40, 8'h20, 24'h934020, "R3 running status reuse");
    send_msg(8'h41, 8'h00, 24'h934100, "R4 zero velocity kept");

    // R6: new status after a lone key drops the key
    send(8'h3C);
    send(8'h85);
    send_msg(8'h30, 8'h10, 24'h853010, "R6 status resets half message");

    // R8: real-time bytes between key and velocity
    expq.push_back(24'h85457F);
    send(8'hFE);
    send(8'h45);
    send(8'hF8);
    send(8'h7F);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_msg == 24'h85457F, "R8 real-time ignored",
        {7'h0, out_valid, out_msg}, {8'h01, 24'h85457F});

    // R7: other status bytes cancel running status
    send(8'hB0); send(8'h07); send(8'h64);
    idle_check("R7 controller status cancels");
    send(8'h93); send(8'h11); send(8'hF0); send(8'h22); send(8'h33);
    idle_check("R7 system status drops pending key");
    send(8'h90);
    send_msg(8'h22, 8'h33, 24'h902233, "R7 recovery on new note status");

    // R9: back-pressure
    @(posedge clk); #2; out_ready = 1'b0;
    expq.push_back(24'h904455);
    expq.push_back(24'h904666);
    send(8'h44); send(8'h55);
    fork
      send(8'h46);
      begin
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk(out_valid && out_msg == 24'h904455 && !in_ready, "R9 stall holds word",
              {6'h0, in_ready, out_valid, out_msg}, {6'h0, 1'b0, 1'b1, 24'h904455});
        end
        @(posedge clk); #2; out_ready = 1'b1;
      end
    join
    send(8'h66);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_msg == 24'h904666, "R9 byte held during stall used",
        {7'h0, out_valid, out_msg}, {8'h01, 24'h904666});

    idle_check("R10 scoreboard drained");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule